// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent page translations for a 32-bit address space divided into 4 KB pages. A requester presents a virtual address together with an access kind (data read, data write or instruction fetch). In the same cycle the block compares the page number against every stored translation. It answers with a hit and the physical address, with a protection fault, or with a miss. The physical address keeps the page offset bits unchanged.

After a miss, an external table walker looks up the translation and delivers it on a fill channel that uses a valid/ready handshake. A fill moves on the rising edge where both `fill_valid` and `fill_ready` are high. While `fill_valid` is high and `fill_ready` is low, the walker must keep `fill_valid` and every fill field stable. The block deasserts `fill_ready` only in a cycle where `inval` is high. Otherwise it takes a fill every cycle.

The block can drop all translations in one cycle, for example on a context switch. The first write through a clean page raises a request so that the walker can mark the page dirty in memory.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `lk_pa[31:12]` is the stored physical page number and `lk_pa[11:0]` equals `lk_va[11:0]`.
- R2: A lookup matches when a valid entry holds the page number `lk_va[31:12]`. The entry can be in any slot. With `lk_valid` high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. With `lk_valid` low, all three are low.
- R3: The access codes on `lk_acc` are 0 = read, 1 = write, 2 = fetch and 3 = read. A read needs the entry's R bit, a write needs its W bit and a fetch needs its X bit. A matching entry without the needed bit gives `lk_fault` and no `lk_hit`.
- R4: A write hit on an entry whose dirty bit is clear raises `dirty_req` in that cycle, with `dirty_vpn` set to the page number. The entry's dirty bit is then set, so a later write to that page does not raise the request again. An entry filled with `fill_d`=1 never raises it.
- R5: A fill is accepted on an edge where `fill_valid` and `fill_ready` are both high. `fill_ready` is low exactly in a cycle where `inval` is high.
- R6: A fill whose page number matches a valid entry overwrites that entry. Otherwise it goes to the lowest-numbered invalid entry. If every entry is valid, it replaces the least recently used entry.
- R7: Recency is updated by each hit and each accepted fill. Misses and faults leave it unchanged.
- R8: A cycle with `inval` high invalidates every entry, so the next lookups miss.
- R9: After reset every entry is invalid, and any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_va | input | 32 | Virtual address of the lookup |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid entry for the page |
| lk_fault | output | 1 | Entry found but access not permitted |
| lk_pa | output | 32 | Physical address (valid on hit) |
| dirty_req | output | 1 | First write through a clean page |
| dirty_vpn | output | 20 | Page number for the dirty request |
| fill_valid | input | 1 | Walker offers a translation |
| fill_ready | output | 1 | Block accepts the fill |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_r | input | 1 | Read permission |
| fill_w | input | 1 | Write permission |
| fill_x | input | 1 | Execute permission |
| fill_d | input | 1 | Page already dirty |
| inval | input | 1 | Invalidate all entries |

## Verification
The checker watches, on every cycle, properties that hold in any state:
- the three lookup outcomes are mutually exclusive and silent when idle;
- the page offset passes through on a hit;
- a dirty request comes only with a write hit;
- the fill handshake is refused during invalidation and stays held under back-pressure;
- a lookup right after an invalidation never hits.

Some properties depend on history and can only be shown by the bench's scenarios:
- which slot a fill lands in;
- that an existing page is overwritten rather than duplicated;
- least-recently-used eviction order after a mix of hits, faults and misses;
- the dirty request being raised only once per page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RDALT = 2'd3
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  // Access allowed for a given permission set
  function automatic logic perm_allows(perm_t p, acc_e a);
    logic ok;
    case (a)
      ACC_WRITE: ok = p.w;
      ACC_FETCH: ok = p.x;
      default:   ok = p.r;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  // lookup side
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit_any,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PPN_W-1:0]   hit_ppn,
  output perm_t              hit_perm,
  output logic               hit_dirty,
  // fill side
  input  logic [VPN_W-1:0]   fl_vpn,
  output logic [ENTRIES-1:0] fl_match,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  perm_t              wr_perm,
  input  logic               wr_dirty,
  // dirty marking
  input  logic               dset_en,
  input  logic [IDX_W-1:0]   dset_idx
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (dset_en) dirty_q[dset_idx] <= 1'b1;
    if (wr_en) begin
      dirty_q[wr_idx] <= wr_dirty;
      vpn_q[wr_idx]   <= fl_vpn;
      ppn_q[wr_idx]   <= wr_ppn;
      perm_q[wr_idx]  <= wr_perm;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    assign fl_match[g] = valid_q[g] && (vpn_q[g] == fl_vpn);
  end

  assign valid_vec = valid_q;
  assign hit_any   = |lk_match;

  // one-hot match vector reduced to the hit entry's fields
  always_comb begin
    hit_ppn   = '0;
    hit_perm  = '0;
    hit_dirty = 1'b0;
    hit_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn   = hit_ppn   | ({PPN_W{lk_match[i]}} & ppn_q[i]);
      hit_perm  = hit_perm  | ({3{lk_match[i]}} & perm_q[i]);
      hit_dirty = hit_dirty | (lk_match[i] & dirty_q[i]);
      if (lk_match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tch_a_en,
  input  logic [IDX_W-1:0] tch_a_idx,
  input  logic             tch_b_en,
  input  logic [IDX_W-1:0] tch_b_idx,
  output logic [IDX_W-1:0] victim
);

  // newer_q[i][j] = 1 when entry i was used more recently than entry j
  logic [ENTRIES-1:0] newer_q [ENTRIES];
  logic [ENTRIES-1:0] newer_n [ENTRIES];

  function automatic void touch(ref logic [ENTRIES-1:0] m [ENTRIES], input int k);
    for (int r = 0; r < ENTRIES; r++) m[r][k] = 1'b0;
    m[k] = '1;
    m[k][k] = 1'b0;
  endfunction

  always_comb begin
    for (int r = 0; r < ENTRIES; r++) newer_n[r] = newer_q[r];
    if (tch_a_en) touch(newer_n, int'(tch_a_idx));
    if (tch_b_en) touch(newer_n, int'(tch_b_idx));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ENTRIES; r++)
        for (int c = 0; c < ENTRIES; c++)
          newer_q[r][c] <= (r > c);
    end else begin
      for (int r = 0; r < ENTRIES; r++) newer_q[r] <= newer_n[r];
    end
  end

  // the oldest entry is newer than nobody
  always_comb begin
    victim = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (newer_q[i] == '0) victim = IDX_W'(i);
  end

endmodule

// File: rtl/xlat_place.sv
module xlat_place #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] fl_match,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   lru_victim,
  output logic [IDX_W-1:0]   place_idx
);

  logic             have_match;
  logic             have_free;
  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fl_match[i])   match_idx = IDX_W'(i);
      if (!valid_vec[i]) free_idx  = IDX_W'(i);
    end
  end

  assign have_match = |fl_match;
  assign have_free  = ~&valid_vec;

  always_comb begin
    if (have_match)     place_idx = match_idx;
    else if (have_free) place_idx = free_idx;
    else                place_idx = lru_victim;
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [1:0]       lk_acc,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_pa,
  output logic             dirty_req,
  output logic [VPN_W-1:0] dirty_vpn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_r,
  input  logic             fill_w,
  input  logic             fill_x,
  input  logic             fill_d,
  input  logic             inval
);

  logic [VPN_W-1:0]   lk_vpn;
  acc_e               acc;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   hit_ppn;
  perm_t              hit_perm;
  logic               hit_dirty;
  logic               allowed;
  logic [ENTRIES-1:0] fl_match;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   place_idx;
  logic               fill_fire;
  perm_t              fill_perm;

  assign lk_vpn    = lk_va[VA_W-1:OFF_W];
  assign acc       = acc_e'(lk_acc);
  assign allowed   = perm_allows(hit_perm, acc);
  assign fill_perm = '{r: fill_r, w: fill_w, x: fill_x};

  assign lk_hit    = lk_valid &  hit_any &  allowed;
  assign lk_fault  = lk_valid &  hit_any & ~allowed;
  assign lk_miss   = lk_valid & ~hit_any;
  assign lk_pa     = {hit_ppn, lk_va[OFF_W-1:0]};

  assign dirty_req = lk_hit && (acc == ACC_WRITE) && !hit_dirty;
  assign dirty_vpn = lk_vpn;

  assign fill_ready = ~inval;
  assign fill_fire  = fill_valid & fill_ready;

  xlat_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (inval),
    .lk_vpn    (lk_vpn),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx),
    .hit_ppn   (hit_ppn),
    .hit_perm  (hit_perm),
    .hit_dirty (hit_dirty),
    .fl_vpn    (fill_vpn),
    .fl_match  (fl_match),
    .valid_vec (valid_vec),
    .wr_en     (fill_fire),
    .wr_idx    (place_idx),
    .wr_ppn    (fill_ppn),
    .wr_perm   (fill_perm),
    .wr_dirty  (fill_d),
    .dset_en   (dirty_req),
    .dset_idx  (hit_idx)
  );

  xlat_lru #(
    .ENTRIES (ENTRIES)
  ) i_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .tch_a_en  (lk_hit),
    .tch_a_idx (hit_idx),
    .tch_b_en  (fill_fire),
    .tch_b_idx (place_idx),
    .victim    (victim)
  );

  xlat_place #(
    .ENTRIES (ENTRIES)
  ) i_place (
    .fl_match   (fl_match),
    .valid_vec  (valid_vec),
    .lru_victim (victim),
    .place_idx  (place_idx)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_va,
  input logic [1:0]      lk_acc,
  input logic            lk_hit,
  input logic            lk_miss,
  input logic            lk_fault,
  input logic [PA_W-1:0] lk_pa,
  input logic            dirty_req,
  input logic            fill_valid,
  input logic            fill_ready,
  input logic            inval
);

  // R2
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit && !lk_miss && !lk_fault);

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]);

  // R4
  dirty_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_req |-> lk_hit && lk_acc == 2'd1);

  // R5
  fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> !fill_ready);

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid);

  // R8
  inval_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !lk_hit && !lk_fault);

endmodule

bind xlat_cache xlat_cache_chk #(
  .VA_W (VA_W),
  .PA_W (PA_W),
  .OFF_W(OFF_W)
) i_xlat_cache_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_va      (lk_va),
  .lk_acc     (lk_acc),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_fault   (lk_fault),
  .lk_pa      (lk_pa),
  .dirty_req  (dirty_req),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .inval      (inval)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_va;
  logic [1:0]  lk_acc;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_pa;
  logic        dirty_req;
  logic [19:0] dirty_vpn;
  logic        fill_valid, fill_ready;
  logic [19:0] fill_vpn, fill_ppn;
  logic        fill_r, fill_w, fill_x, fill_d;
  logic        inval;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pa(lk_pa),
    .dirty_req(dirty_req), .dirty_vpn(dirty_vpn),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_r(fill_r), .fill_w(fill_w), .fill_x(fill_x), .fill_d(fill_d),
    .inval(inval)
  );

  // expected outcome: {hit, miss, fault, dirty}
  logic [3:0]  exp_q [$];
  logic [31:0] exp_pa_q [$];
  string       exp_tag_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pops one expected item per lookup cycle
  always @(negedge clk) begin
    if (rst_n && lk_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected lookup", 64'(lk_va), 64'(0));
      end else begin
        logic [3:0]  e;
        logic [31:0] epa;
        string       t;
        e   = exp_q.pop_front();
        epa = exp_pa_q.pop_front();
        t   = exp_tag_q.pop_front();
        chk({lk_hit, lk_miss, lk_fault, dirty_req} == e, t,
            64'({lk_hit, lk_miss, lk_fault, dirty_req}), 64'(e));
        if (e[3]) chk(lk_pa == epa, t, 64'(lk_pa), 64'(epa));
        if (e[0]) chk(dirty_vpn == lk_va[31:12], t, 64'(dirty_vpn), 64'(lk_va[31:12]));
      end
    end
  end

  // driver: called just after a rising edge
  task automatic look(input logic [31:0] va, input logic [1:0] acc,
                      input logic [3:0] e, input logic [31:0] epa, input string tag);
    lk_valid = 1'b1;
    lk_va    = va;
    lk_acc   = acc;
    exp_q.push_back(e);
    exp_pa_q.push_back(epa);
    exp_tag_q.push_back(tag);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic r, input logic w, input logic x, input logic d);
    fill_valid = 1'b1;
    fill_vpn = vpn; fill_ppn = ppn;
    fill_r = r; fill_w = w; fill_x = x; fill_d = d;
    @(negedge clk);
    while (!fill_ready) @(negedge clk);
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  localparam logic [3:0] E_HIT = 4'b1000, E_MISS = 4'b0100, E_FLT = 4'b0010, E_HITD = 4'b1001;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_acc = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0;
    fill_r = 0; fill_w = 0; fill_x = 0; fill_d = 0; inval = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    // R9: empty after reset, fill channel open (R5)
    @(negedge clk);
    chk(fill_ready == 1'b1, "R5 ready idle", 64'(fill_ready), 64'(1));
    chk({lk_hit, lk_miss, lk_fault} == 3'b000, "R2 idle outputs", 64'({lk_hit, lk_miss, lk_fault}), 64'(0));
    @(posedge clk); #1;
    look(32'h1234_5678, 2'd0, E_MISS, 32'h0, "R9 miss after reset");

    // fill 16 pages: 0 RWX, 1 R only, 2 X only, 3 RW dirty, others RW
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: fill(20'h10000 + 20'(i), 20'h40000 + 20'(i), 1, 1, 1, 0);
        1: fill(20'h10000 + 20'(i), 20'h40000 + 20'(i), 1, 0, 0, 0);
        2: fill(20'h10000 + 20'(i), 20'h40000 + 20'(i), 0, 0, 1, 0);
        3: fill(20'h10000 + 20'(i), 20'h40000 + 20'(i), 1, 1, 0, 1);
        default: fill(20'h10000 + 20'(i), 20'h40000 + 20'(i), 1, 1, 0, 0);
      endcase
    end

    look(32'h1000_0ABC, 2'd0, E_HIT, 32'h4000_0ABC, "R1 read hit");
    look(32'h1000_F123, 2'd3, E_HIT, 32'h4000_F123, "R2 last slot, code 3 read");
    look(32'h1000_1004, 2'd1, E_FLT, 32'h0, "R3 write to read-only");
    look(32'h1000_2010, 2'd0, E_FLT, 32'h0, "R3 read without R");
    look(32'h1000_2FFF, 2'd2, E_HIT, 32'h4000_2FFF, "R3 fetch allowed");
    look(32'h1000_1000, 2'd2, E_FLT, 32'h0, "R3 fetch without X");
    look(32'h1000_4040, 2'd1, E_HITD, 32'h4000_4040, "R4 first write raises request");
    look(32'h1000_4044, 2'd1, E_HIT, 32'h4000_4044, "R4 second write silent");
    look(32'h1000_3000, 2'd1, E_HIT, 32'h4000_3000, "R4 filled dirty page silent");

    // R7: oldest is page 10001 (faults did not refresh it)
    fill(20'h20000, 20'h55555, 1, 1, 0, 0);
    look(32'h1000_1000, 2'd0, E_MISS, 32'h0, "R7 LRU victim evicted");
    look(32'h2000_0321, 2'd0, E_HIT, 32'h5555_5321, "R6 new page installed");

    // R6: refill existing page overwrites it in place
    fill(20'h10006, 20'h66666, 1, 1, 0, 0);
    look(32'h1000_6ABC, 2'd0, E_HIT, 32'h6666_6ABC, "R6 overwrite same page");
    look(32'h1000_5ABC, 2'd0, E_HIT, 32'h4000_5ABC, "R6 no eviction on overwrite");
    fill(20'h30000, 20'h77777, 1, 1, 0, 0);
    look(32'h1000_7000, 2'd0, E_MISS, 32'h0, "R7 next LRU evicted");
    look(32'h3000_0001, 2'd0, E_HIT, 32'h7777_7001, "R7 replacement present");

    // R8 invalidate; R5 ready low during it
    inval = 1'b1;
    @(negedge clk);
    chk(fill_ready == 1'b0, "R5 ready low on invalidate", 64'(fill_ready), 64'(0));
    @(posedge clk); #1;
    inval = 1'b0;
    look(32'h1000_0000, 2'd0, E_MISS, 32'h0, "R8 miss after invalidate");
    look(32'h3000_0000, 2'd2, E_MISS, 32'h0, "R8 miss after invalidate");

    fill(20'h40000, 20'h0ABCD, 1, 0, 1, 0);
    look(32'h4000_0FFF, 2'd2, E_HIT, 32'h0ABC_DFFF, "R6 fill into free slot");

    @(posedge clk); #1;
    chk(exp_q.size() == 0, "R2 all lookups seen", 64'(exp_q.size()), 64'(0));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule